// File: doc/BRIEF.md
# Re-quantized Sigma-Delta Divider Controller

This block drives a fractional-N synthesizer loop that has a programmable divider and a chain of switchable delay elements. On every reference-cycle strobe it produces two control values. The first is a signed divider offset from a third-order cascaded (MASH) modulator that is fed a 20-bit fractional word. The long-run mean of this offset equals the fraction. The second is an element count. It says how many delay elements should take their slow path in that cycle, so that the phase error the divider offset leaves behind is cancelled with a resolution of one eighth of an oscillator period.

To form the count, the block runs each cycle's quantization error (offset minus fraction) through an accumulator and negates it. The result is read with a scale of eight, which costs no logic because it only moves the binary point three places. It is then split into a signed integer part and a 17-bit fraction. The fraction is re-shaped by a second-order MASH modulator, and its output is added back to the integer part. A fixed bias of half the element count is added so the result is never negative, and the sum is clamped to the number of elements. A sticky flag records any clamping. Because the fraction is noise-shaped rather than truncated, a gain error in the delay elements appears high-pass filtered at the synthesizer output.

The strobe `ref_tick` acts as a valid with no ready. The block takes every strobe and cannot apply back-pressure. Both outputs are registered and hold their values between strobes, so the divider and the delay chain may sample them at any time within the reference cycle.

Top module: `sdm_divctl`

## Requirements
- R1: A synchronous reset clears every accumulator, integrator and history register. After it, `div_ofs` is 0, `elem_cnt` is 16 and `clip_seen` is 0. Reset takes priority over `ref_tick` in the same cycle.
- R2: On each strobe, `div_ofs` (4-bit two's complement) takes the value c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here c1..c3 are the carries of three cascaded 20-bit accumulators, where each stage adds the new sum of the stage before it, and primes mark the values from one and two strobes earlier. The value always lies in -3..+4.
- R3: Starting from reset with a constant word x, where 64*x is a multiple of 2^20, the sum of `div_ofs` over 64 strobes lies between 64*x/2^20 - 1 and 64*x/2^20 + 2.
- R4: The integrator adds `div_ofs`*2^20 - x on each strobe. Its negated value, read with 17 fractional bits, gives a signed integer part and a 17-bit fraction. `elem_cnt` (unsigned, 6 bits) equals the integer part plus the second-order modulator output plus 16. It updates on the same strobe as the `div_ofs` it compensates.
- R5: The second-order modulator is two cascaded 17-bit accumulators driven by the fraction. Its output c1 + (c2 - c2') lies in -1..+2.
- R6: `elem_cnt` never exceeds 32. A sum below 0 gives 0 and a sum above 32 gives 32. Either case sets `clip_seen`, which stays set until reset.
- R7: While `ref_tick` is low, no state changes and the outputs hold, whatever `frac_word` does.
- R8: A zero fractional word keeps `div_ofs` at 0 and `elem_cnt` at 16 indefinitely.
- R9: A reset in the middle of a run restarts the output sequence exactly as it ran from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| frac_word | input | 20 | Unsigned fractional division word |
| div_ofs | output | 4 | Signed divider modulus offset |
| elem_cnt | output | 6 | Number of delay elements on the slow path (0..32) |
| clip_seen | output | 1 | Sticky flag: the element count was clamped |

## Verification
The bench uses the default parameters: a 20-bit word, a scale shift of 3 and 32 elements. With these, fractions that are multiples of 2^14 return the first accumulator to zero after 64 strobes, which makes the sum bound of R3 exact and checkable. These widths also keep the integrator within a few units of the element midpoint, so an independent integer model in the bench can follow both streams strobe by strobe. This covers a full-scale word, a pseudo-random sweep, held strobes and a reset while a strobe is asserted.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Lowest value a MASH of the given order can emit
  function automatic int mash_lo(input int order);
    return 1 - (1 << (order - 1));
  endfunction

  // Highest value a MASH of the given order can emit
  function automatic int mash_hi(input int order);
    return 1 << (order - 1);
  endfunction

endpackage

// File: rtl/sdm_mash_core.sv
module sdm_mash_core #(
  parameter int W     = 20,
  parameter int ORDER = 3,
  parameter int OUT_W = ORDER + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [W-1:0]            x,
  output logic signed [OUT_W-1:0] y
);
  import sdm_pkg::*;

  localparam int LO = mash_lo(ORDER);
  localparam int HI = mash_hi(ORDER);

  logic [ORDER-1:0][W-1:0] acc_q;
  logic [ORDER-1:0][W-1:0] acc_nx;
  logic [ORDER-1:0]        cy;

  // cascaded accumulators: each stage adds the fresh sum of the stage before
  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [W:0] tot;
    if (g == 0) begin : g_head
      assign tot = {1'b0, acc_q[g]} + {1'b0, x};
    end else begin : g_tail
      assign tot = {1'b0, acc_q[g]} + {1'b0, acc_nx[g-1]};
    end
    assign acc_nx[g] = tot[W-1:0];
    assign cy[g]     = tot[W];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nx;
  end

  // carry cancellation network
  if (ORDER == 1) begin : g_o1
    assign y = OUT_W'(cy[0]);
  end else if (ORDER == 2) begin : g_o2
    logic c2_d;
    logic signed [OUT_W-1:0] k1, k2, k2d;
    assign k1  = OUT_W'(cy[0]);
    assign k2  = OUT_W'(cy[1]);
    assign k2d = OUT_W'(c2_d);
    assign y   = k1 + k2 - k2d;
    always_ff @(posedge clk) begin
      if (rst)     c2_d <= 1'b0;
      else if (en) c2_d <= cy[1];
    end
  end else begin : g_o3
    logic c2_d, c3_d, c3_dd;
    logic signed [OUT_W-1:0] k1, k2, k2d, k3, k3d, k3dd;
    assign k1   = OUT_W'(cy[0]);
    assign k2   = OUT_W'(cy[1]);
    assign k2d  = OUT_W'(c2_d);
    assign k3   = OUT_W'(cy[2]);
    assign k3d  = OUT_W'(c3_d);
    assign k3dd = OUT_W'(c3_dd);
    assign y    = k1 + k2 - k2d + k3 - (k3d <<< 1) + k3dd;
    always_ff @(posedge clk) begin
      if (rst) begin
        c2_d  <= 1'b0;
        c3_d  <= 1'b0;
        c3_dd <= 1'b0;
      end else if (en) begin
        c2_d  <= cy[1];
        c3_d  <= cy[2];
        c3_dd <= c3_d;
      end
    end
  end

  // R2 R5
  y_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (y >= LO && y <= HI));

endmodule

// File: rtl/sdm_clip.sv
module sdm_clip #(
  parameter int IN_W  = 8,
  parameter int MAXV  = 32,
  parameter int OUT_W = 6
) (
  input  logic signed [IN_W-1:0] raw,
  output logic [OUT_W-1:0]       val,
  output logic                   hit
);
  localparam logic signed [IN_W-1:0] LIM = IN_W'(MAXV);

  always_comb begin
    if (raw < 0) begin
      val = '0;
      hit = 1'b1;
    end else if (raw > LIM) begin
      val = OUT_W'(MAXV);
      hit = 1'b1;
    end else begin
      val = raw[OUT_W-1:0];
      hit = 1'b0;
    end
  end

endmodule

// File: rtl/sdm_divctl.sv
module sdm_divctl #(
  parameter int FRAC_W  = 20,
  parameter int P_SHIFT = 3,
  parameter int N_ELEM  = 32,
  parameter int ORD_DIV = 3,
  parameter int ORD_DLY = 2,
  localparam int Y_W    = ORD_DIV + 1,
  localparam int P_W    = $clog2(N_ELEM + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_tick,
  input  logic [FRAC_W-1:0]     frac_word,
  output logic signed [Y_W-1:0] div_ofs,
  output logic [P_W-1:0]        elem_cnt,
  output logic                  clip_seen
);
  localparam int INTG_W   = FRAC_W + P_SHIFT;
  localparam int RQ_W     = FRAC_W - P_SHIFT;
  localparam int IPART_W  = INTG_W - RQ_W;
  localparam int Q_W      = ORD_DLY + 1;
  localparam int WK_W     = ((IPART_W > P_W) ? IPART_W : P_W) + 2;
  localparam int P_OFFSET = N_ELEM / 2;
  localparam logic signed [INTG_W-1:0] ISUM_LIM = INTG_W'(2) <<< FRAC_W;

  logic signed [Y_W-1:0]    y_c;
  logic signed [Q_W-1:0]    q_c;
  logic signed [INTG_W-1:0] isum_q, isum_nx, err_step, neg_sum, y_ext;
  logic signed [IPART_W-1:0] ipart;
  logic [RQ_W-1:0]          fpart;
  logic signed [WK_W-1:0]   p_raw;
  logic [P_W-1:0]           p_c;
  logic                     p_hit;

  sdm_mash_core #(.W(FRAC_W), .ORDER(ORD_DIV), .OUT_W(Y_W)) u_div_mod (
    .clk (clk),
    .rst (rst),
    .en  (ref_tick),
    .x   (frac_word),
    .y   (y_c)
  );

  // quantization error of this strobe, in units of 2^-FRAC_W
  assign y_ext    = {{(INTG_W-Y_W){y_c[Y_W-1]}}, y_c};
  assign err_step = (y_ext <<< FRAC_W) - $signed({{P_SHIFT{1'b0}}, frac_word});
  assign isum_nx  = isum_q + err_step;

  // negate; reading with RQ_W fraction bits is the scale by 2^P_SHIFT
  assign neg_sum = -isum_nx;
  assign ipart   = neg_sum[INTG_W-1:RQ_W];
  assign fpart   = neg_sum[RQ_W-1:0];

  sdm_mash_core #(.W(RQ_W), .ORDER(ORD_DLY), .OUT_W(Q_W)) u_dly_mod (
    .clk (clk),
    .rst (rst),
    .en  (ref_tick),
    .x   (fpart),
    .y   (q_c)
  );

  assign p_raw = {{(WK_W-IPART_W){ipart[IPART_W-1]}}, ipart}
               + {{(WK_W-Q_W){q_c[Q_W-1]}}, q_c}
               + WK_W'(P_OFFSET);

  sdm_clip #(.IN_W(WK_W), .MAXV(N_ELEM), .OUT_W(P_W)) u_clip (
    .raw (p_raw),
    .val (p_c),
    .hit (p_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isum_q    <= '0;
      div_ofs   <= '0;
      elem_cnt  <= P_W'(P_OFFSET);
      clip_seen <= 1'b0;
    end else if (ref_tick) begin
      isum_q    <= isum_nx;
      div_ofs   <= y_c;
      elem_cnt  <= p_c;
      clip_seen <= clip_seen | p_hit;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (div_ofs == 0 && elem_cnt == P_W'(P_OFFSET) && !clip_seen));

  // R4
  integ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (isum_q >= -ISUM_LIM && isum_q <= ISUM_LIM));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    elem_cnt <= P_W'(N_ELEM));

  // R6
  clip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clip_seen |=> clip_seen);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> ($stable(div_ofs) && $stable(elem_cnt) && $stable(isum_q)));

endmodule

// File: tb/tb_sdm_divctl.sv
module tb_sdm_divctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [19:0] frac = '0;
  logic signed [3:0] ofs;
  logic [5:0]  cnt;
  logic        clip;

  sdm_divctl dut (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (tick),
    .frac_word (frac),
    .div_ofs   (ofs),
    .elem_cnt  (cnt),
    .clip_seen (clip)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  localparam longint M1 = 64'd1 << 20;
  localparam longint M2 = 64'd1 << 17;

  // word, expected 64-strobe sum of the divider offset
  localparam int NV = 6;
  localparam int TV_X[NV]   = '{0, 524288, 262144, 1032192, 16384, 196608};
  localparam int TV_SUM[NV] = '{0, 32, 16, 63, 1, 12};

  // independent integer model of the requirements
  longint ma1, ma2, ma3, mb1, mb2, misum;
  longint mc2d, mc3d, mc3dd, md2d;
  longint my, mp;
  bit     msat;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    ma1 = 0; ma2 = 0; ma3 = 0; mb1 = 0; mb2 = 0; misum = 0;
    mc2d = 0; mc3d = 0; mc3dd = 0; md2d = 0;
    my = 0; mp = 16; msat = 1'b0;
  endtask

  task automatic model_step(input longint x);
    longint s, c1, c2, c3, neg, ip, fr, e1, e2, q2, pr;
    s = ma1 + x;   c1 = (s >= M1); ma1 = s % M1;
    s = ma2 + ma1; c2 = (s >= M1); ma2 = s % M1;
    s = ma3 + ma2; c3 = (s >= M1); ma3 = s % M1;
    my = c1 + c2 - mc2d + c3 - 2 * mc3d + mc3dd;
    mc3dd = mc3d; mc3d = c3; mc2d = c2;
    misum = misum + my * M1 - x;
    neg = -misum;
    ip  = neg >>> 17;
    fr  = neg & (M2 - 1);
    s = mb1 + fr;  e1 = (s >= M2); mb1 = s % M2;
    s = mb2 + mb1; e2 = (s >= M2); mb2 = s % M2;
    q2 = e1 + e2 - md2d;
    md2d = e2;
    pr = ip + q2 + 16;
    if (pr < 0) begin mp = 0; msat = 1'b1; end
    else if (pr > 32) begin mp = 32; msat = 1'b1; end
    else mp = pr;
  endtask

  task automatic tick_once(input longint x);
    frac = x[19:0];
    tick = 1'b1;
    @(posedge clk);
    #2;
    tick = 1'b0;
    model_step(x);
    chk("R2 divider offset", ofs, my);
    chk("R4 R5 element count", cnt, mp);
    chk("R6 clip flag", clip, msat);
  endtask

  task automatic do_reset();
    rst  = 1'b1;
    tick = 1'b0;
    @(posedge clk);
    #2;
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    longint sum;
    logic signed [3:0] o_hold;
    logic [5:0] c_hold;
    logic f_hold;

    model_reset();
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1
    chk("R1 offset after reset", ofs, 0);
    chk("R1 count after reset", cnt, 16);
    chk("R1 clip after reset", clip, 0);

    // R3 average over table of words
    for (int i = 0; i < NV; i++) begin
      do_reset();
      sum = 0;
      for (int k = 0; k < 64; k++) begin
        tick_once(TV_X[i]);
        sum += ofs;
      end
      n_chk++;
      if (sum < TV_SUM[i] - 1 || sum > TV_SUM[i] + 2) begin
        n_err++;
        $display("FAIL R3 sum for word %0d: actual %0d expected %0d (-1..+2)",
                 TV_X[i], sum, TV_SUM[i]);
      end
    end

    // full-scale word
    do_reset();
    repeat (300) tick_once(20'hFFFFF);

    // pseudo-random sweep without reset
    for (int k = 0; k < 400; k++) tick_once((k * 40503 + 911) % M1);

    // R7 hold with idle strobe and a moving word
    o_hold = ofs; c_hold = cnt; f_hold = clip;
    for (int k = 0; k < 6; k++) begin
      frac = 20'(32'h5A5A5 + k * 777);
      @(posedge clk);
      #2;
      chk("R7 hold offset", ofs, o_hold);
      chk("R7 hold count", cnt, c_hold);
      chk("R7 hold clip", clip, f_hold);
    end
    // R7 state untouched: sequence continues matching the model
    repeat (50) tick_once(333333);

    // R8 zero word
    do_reset();
    for (int k = 0; k < 100; k++) begin
      tick_once(0);
      chk("R8 zero word offset", ofs, 0);
      chk("R8 zero word count", cnt, 16);
    end

    // R9 mid-run reset with the strobe also high
    do_reset();
    repeat (37) tick_once(700001);
    rst = 1'b1; tick = 1'b1; frac = 20'd700001;
    @(posedge clk);
    #2;
    rst = 1'b0; tick = 1'b0;
    model_reset();
    chk("R9 R1 offset after mid reset", ofs, 0);
    chk("R9 R1 count after mid reset", cnt, 16);
    chk("R9 R1 clip after mid reset", clip, 0);
    repeat (37) tick_once(700001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule